// File: doc/BRIEF.md
# Colour Dither Reducer

This block narrows a stream of 24-bit RGB pixels (three components of `IN_W` bits each) to `OUT_W` bits per component, for example 12-bit RGB with 4 bits per component. Before the low `K = IN_W - OUT_W` bits of each component are dropped, a dither value in the range 0 to 2^K-1 is added. The method is chosen at run time by a two-bit mode input:

- plain truncation;
- white noise, taken from a shared 16-bit LFSR;
- one-dimensional error diffusion, where the bits dropped from one pixel are carried into the next pixel of the same line.

Two enables add noisy starting points. With line seeding on, error diffusion starts each line from a noise value instead of zero. With frame seeding on, the noise generator is reloaded at every frame start from a value that mixes in a running frame count, which gives temporal dithering.

The input is a pixel stream with a valid strobe and line-start and frame-start markers. The output is registered with one clock of latency, and the strobe and markers travel with the data. Setting the parameter `DITHER_EN` to 0 removes the whole dither path, and the full-width colour then passes through the same one-cycle register. Component c of a pixel occupies bits [c*IN_W +: IN_W] at the input and bits [c*OUT_W +: OUT_W] at the output.

Top module: `color_dither`

## Requirements
- R1: In mode 0 each output component equals the upper OUT_W bits of the matching input component.
- R2: out_valid_o equals pix_valid_i of the previous cycle. out_sol_o and out_sof_o are the previous cycle's markers qualified by valid. After reset all outputs are 0.
- R3: The sum of a component and its dither saturates at 2^IN_W-1, so an all-ones component yields an all-ones output in every mode.
- R4: In mode 1 the dither for component c is bits [5c +: K] of the generator state used for that pixel.
- R5: The generator is a 16-bit Galois LFSR that shifts right and XORs the mask 0xB400 when the bit shifted out is 1. It resets to SEED (0xACE1 by default) and advances exactly once per valid pixel in every mode, never on idle cycles.
- R6: In mode 2, a pixel that is not a line start uses as its dither the low K bits of the saturated sum of the previous valid pixel in the same component.
- R7: In mode 2, a line-start pixel uses dither 0 when line seeding is off, and the R4 noise slice when it is on.
- R8: A valid frame-start pixel with frame seeding on uses the generator state SEED ^ (F << 1), where F counts the earlier valid frame-start pixels since reset, modulo 2^16. With frame seeding off, no reload happens.
- R9: Mode 3 behaves exactly as mode 0.
- R10: On cycles without a valid input, out_rgb_o holds its previous value.
- R11: With DITHER_EN = 0, out_rgb_o is the full-width input pixel delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Dither method: 0 off, 1 noise, 2 error diffusion, 3 off |
| line_seed_en_i | input | 1 | Seed the diffusion residual with noise at line start |
| frame_seed_en_i | input | 1 | Reload the noise generator at frame start |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_sol_i | input | 1 | Input pixel is the first of a line |
| pix_sof_i | input | 1 | Input pixel is the first of a frame |
| pix_rgb_i | input | 3*IN_W | Input pixel |
| out_valid_o | output | 1 | Output pixel valid |
| out_sol_o | output | 1 | Output line-start marker |
| out_sof_o | output | 1 | Output frame-start marker |
| out_rgb_o | output | 3*OW | Output pixel; OW is OUT_W, or IN_W when DITHER_EN is 0 |

## Verification
The assertions check on every cycle that the strobe and markers lag the input by exactly one clock, that idle cycles leave the pixel unchanged, that modes 0 and 3 truncate, and that a saturated component never wraps to zero. The exact noise sequence, the carry of residuals from pixel to pixel along a line, line and frame seeding, and the pass-through variant depend on history over many pixels. Only the bench's behavioural model can show these, by comparing every output cycle across directed lines, frames, idle gaps and a long random run.

// File: rtl/dither_pkg.sv
package dither_pkg;

    typedef enum logic [1:0] {
        DM_OFF     = 2'd0,
        DM_NOISE   = 2'd1,
        DM_DIFFUSE = 2'd2,
        DM_RSVD    = 2'd3
    } dmode_e;

    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_MASK = 16'hB400;
    localparam int          SLICE_GAP = 5;

    typedef struct packed {
        logic valid;
        logic sol;
        logic sof;
    } mark_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        logic [LFSR_W-1:0] n;
        n = s >> 1;
        if (s[0]) n = n ^ LFSR_MASK;
        return n;
    endfunction

endpackage

// File: rtl/dither_noise.sv
module dither_noise
    import dither_pkg::*;
#(
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic              sof_i,
    input  logic              frame_en_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] lfsr_q;
    logic [LFSR_W-1:0] fcnt_q;

    // Frame reload bypasses the register so the first pixel already sees it.
    always_comb begin
        if (sof_i && frame_en_i)
            state_o = SEED ^ {fcnt_q[LFSR_W-2:0], 1'b0};
        else
            state_o = lfsr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= SEED;
            fcnt_q <= '0;
        end else if (adv_i) begin
            lfsr_q <= lfsr_step(state_o);
            if (sof_i) fcnt_q <= fcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/dither_lane.sv
module dither_lane
    import dither_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = 4,
    parameter int IDX   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              sol_i,
    input  dmode_e            mode_i,
    input  logic              line_en_i,
    input  logic [LFSR_W-1:0] noise_i,
    input  logic [IN_W-1:0]   comp_i,
    output logic [OUT_W-1:0]  comp_o
);

    localparam int K = IN_W - OUT_W;

    logic [K-1:0]    err_q;
    logic [K-1:0]    slice;
    logic [K-1:0]    dith;
    logic [IN_W:0]   sum;
    logic [IN_W-1:0] sat;

    assign slice = noise_i[IDX*SLICE_GAP +: K];

    always_comb begin
        unique case (mode_i)
            DM_NOISE:   dith = slice;
            DM_DIFFUSE: dith = sol_i ? (line_en_i ? slice : '0) : err_q;
            default:    dith = '0;
        endcase
        sum = {1'b0, comp_i} + {{(IN_W+1-K){1'b0}}, dith};
        sat = sum[IN_W] ? {IN_W{1'b1}} : sum[IN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            comp_o <= '0;
            err_q  <= '0;
        end else if (valid_i) begin
            comp_o <= sat[IN_W-1:K];
            err_q  <= sat[K-1:0];
        end
    end

endmodule

// File: rtl/color_dither.sv
module color_dither
    import dither_pkg::*;
#(
    parameter int          IN_W      = 8,
    parameter int          OUT_W     = 4,
    parameter bit          DITHER_EN = 1'b1,
    parameter logic [15:0] SEED      = 16'hACE1,
    localparam int         OW        = DITHER_EN ? OUT_W : IN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_i,
    input  logic              line_seed_en_i,
    input  logic              frame_seed_en_i,
    input  logic              pix_valid_i,
    input  logic              pix_sol_i,
    input  logic              pix_sof_i,
    input  logic [3*IN_W-1:0] pix_rgb_i,
    output logic              out_valid_o,
    output logic              out_sol_o,
    output logic              out_sof_o,
    output logic [3*OW-1:0]   out_rgb_o
);

    mark_t mark_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mark_q <= '0;
        end else begin
            mark_q.valid <= pix_valid_i;
            mark_q.sol   <= pix_valid_i & pix_sol_i;
            mark_q.sof   <= pix_valid_i & pix_sof_i;
        end
    end

    assign out_valid_o = mark_q.valid;
    assign out_sol_o   = mark_q.sol;
    assign out_sof_o   = mark_q.sof;

    generate
        if (DITHER_EN) begin : g_dither
            logic [LFSR_W-1:0] noise_state;
            dmode_e            mode_e;

            assign mode_e = dmode_e'(mode_i);

            dither_noise #(.SEED(SEED)) u_noise (
                .clk        (clk),
                .rst        (rst),
                .adv_i      (pix_valid_i),
                .sof_i      (pix_sof_i),
                .frame_en_i (frame_seed_en_i),
                .state_o    (noise_state)
            );

            for (genvar c = 0; c < 3; c++) begin : g_lane
                dither_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .IDX(c)) u_lane (
                    .clk       (clk),
                    .rst       (rst),
                    .valid_i   (pix_valid_i),
                    .sol_i     (pix_sol_i),
                    .mode_i    (mode_e),
                    .line_en_i (line_seed_en_i),
                    .noise_i   (noise_state),
                    .comp_i    (pix_rgb_i[c*IN_W +: IN_W]),
                    .comp_o    (out_rgb_o[c*OUT_W +: OUT_W])
                );
            end
        end else begin : g_pass
            always_ff @(posedge clk) begin
                if (rst)              out_rgb_o <= '0;
                else if (pix_valid_i) out_rgb_o <= pix_rgb_i;
            end
        end
    endgenerate

endmodule

// File: rtl/color_dither_chk.sv
module color_dither_chk #(
    parameter int IN_W      = 8,
    parameter int OW        = 4,
    parameter bit DITHER_EN = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode_i,
    input logic              pix_valid_i,
    input logic              pix_sol_i,
    input logic              pix_sof_i,
    input logic [3*IN_W-1:0] pix_rgb_i,
    input logic              out_valid_o,
    input logic              out_sol_o,
    input logic              out_sof_o,
    input logic [3*OW-1:0]   out_rgb_o
);

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        pix_valid_i |=> out_valid_o); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_i |=> (!out_valid_o && !out_sol_o && !out_sof_o)); // R2
    AST_SOL_DELAY: assert property (@(posedge clk) disable iff (rst)
        (pix_valid_i && pix_sol_i) |=> out_sol_o); // R2
    AST_SOF_DELAY: assert property (@(posedge clk) disable iff (rst)
        (pix_valid_i && pix_sof_i) |=> out_sof_o); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_i |=> $stable(out_rgb_o)); // R10

    generate
        if (DITHER_EN) begin : g_chk
            localparam int K = IN_W - OW;
            logic [3*OW-1:0] trunc;
            always_comb begin
                for (int c = 0; c < 3; c++)
                    trunc[c*OW +: OW] = pix_rgb_i[c*IN_W + K +: OW];
            end
            AST_OFF_TRUNC: assert property (@(posedge clk) disable iff (rst)
                (pix_valid_i && (mode_i == 2'd0)) |=> out_rgb_o == $past(trunc)); // R1
            AST_RSVD_TRUNC: assert property (@(posedge clk) disable iff (rst)
                (pix_valid_i && (mode_i == 2'd3)) |=> out_rgb_o == $past(trunc)); // R9
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
                (pix_valid_i && (&pix_rgb_i[IN_W-1:0])) |=> (&out_rgb_o[OW-1:0])); // R3
        end
    endgenerate

endmodule

bind color_dither color_dither_chk #(.IN_W(IN_W), .OW(OW), .DITHER_EN(DITHER_EN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode_i      (mode_i),
    .pix_valid_i (pix_valid_i),
    .pix_sol_i   (pix_sol_i),
    .pix_sof_i   (pix_sof_i),
    .pix_rgb_i   (pix_rgb_i),
    .out_valid_o (out_valid_o),
    .out_sol_o   (out_sol_o),
    .out_sof_o   (out_sof_o),
    .out_rgb_o   (out_rgb_o)
);

// File: tb/color_dither_tb.sv
module color_dither_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SEED       = 'hACE1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode_i = '0;
    logic        line_seed_en_i = 1'b0;
    logic        frame_seed_en_i = 1'b0;
    logic        pix_valid_i = 1'b0;
    logic        pix_sol_i = 1'b0;
    logic        pix_sof_i = 1'b0;
    logic [23:0] pix_rgb_i = '0;
    logic        out_valid_o, out_sol_o, out_sof_o;
    logic [11:0] out_rgb_o;
    logic        raw_valid, raw_sol, raw_sof;
    logic [23:0] raw_rgb;

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference state
    int m_lfsr = SEED;
    int m_fcnt = 0;
    int m_err[3] = '{0, 0, 0};
    int exp_rgb = 0;
    int exp_raw = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    color_dither u_dut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .line_seed_en_i(line_seed_en_i), .frame_seed_en_i(frame_seed_en_i),
        .pix_valid_i(pix_valid_i), .pix_sol_i(pix_sol_i), .pix_sof_i(pix_sof_i),
        .pix_rgb_i(pix_rgb_i), .out_valid_o(out_valid_o), .out_sol_o(out_sol_o),
        .out_sof_o(out_sof_o), .out_rgb_o(out_rgb_o)
    );

    color_dither #(.DITHER_EN(1'b0)) u_raw (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .line_seed_en_i(line_seed_en_i), .frame_seed_en_i(frame_seed_en_i),
        .pix_valid_i(pix_valid_i), .pix_sol_i(pix_sol_i), .pix_sof_i(pix_sof_i),
        .pix_rgb_i(pix_rgb_i), .out_valid_o(raw_valid), .out_sol_o(raw_sol),
        .out_sof_o(raw_sof), .out_rgb_o(raw_rgb)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int step(input int s);
        int n;
        n = s >> 1;
        if (s & 1) n = n ^ 'hB400;
        return n & 'hFFFF;
    endfunction

    // one cycle: drive at negedge, model, compare after the edge
    task automatic px(input bit v, input bit sol, input bit sof, input int rgb,
                      input int md, input bit le, input bit fe, input string tag);
        int L, n, d, s;
        mode_i = md[1:0]; line_seed_en_i = le; frame_seed_en_i = fe;
        pix_valid_i = v; pix_sol_i = sol; pix_sof_i = sof; pix_rgb_i = rgb[23:0];
        if (v) begin
            L = (sof && fe) ? (SEED ^ ((m_fcnt << 1) & 'hFFFF)) : m_lfsr;
            exp_rgb = 0;
            for (int c = 0; c < 3; c++) begin
                n = (L >> (5*c)) & 15;
                case (md)
                    1: d = n;
                    2: d = sol ? (le ? n : 0) : m_err[c];
                    default: d = 0;
                endcase
                s = ((rgb >> (8*c)) & 255) + d;
                if (s > 255) s = 255;
                exp_rgb = exp_rgb | ((s >> 4) << (4*c));
                m_err[c] = s & 15;
            end
            m_lfsr = step(L);
            if (sof) m_fcnt = (m_fcnt + 1) & 'hFFFF;
            exp_raw = rgb & 'hFFFFFF;
        end
        @(posedge clk);
        #2;
        check("R2 valid", out_valid_o, v);
        check("R2 sol", out_sol_o, v & sol);
        check("R2 sof", out_sof_o, v & sof);
        check(tag, out_rgb_o, exp_rgb);
        check("R11 raw", raw_rgb, exp_raw);
        check("R11 raw valid", raw_valid, v);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD*200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R2 reset valid", out_valid_o, 0);
        check("R2 reset rgb", out_rgb_o, 0);
        check("R11 reset raw", raw_rgb, 0);
        rst = 1'b0;

        // R1 truncation, R9 reserved mode
        for (int i = 0; i < 8; i++) px(1, i == 0, i == 0, 'h10305F + i*'h0A1B2C, 0, 0, 0, "R1");
        for (int i = 0; i < 6; i++) px(1, 0, 0, 'h7F8F9F - i*'h030507, 3, 0, 0, "R9");
        // R10 idle: inputs change, output holds
        for (int i = 0; i < 3; i++) px(0, 1, 1, 'hFFFFFF - i, 1, 1, 1, "R10");
        // R4 and R5 noise, with idle gaps
        for (int i = 0; i < 30; i++) px(1, i == 0, 0, 'h404040 + i*'h010203, 1, 0, 0, "R4");
        for (int i = 0; i < 20; i++) px(i % 3 != 0, 0, 0, 'h102030 + i, 1, 0, 0, "R5");
        // R3 saturation in each mode
        for (int m = 0; m < 3; m++)
            for (int i = 0; i < 5; i++) px(1, i == 0, 0, 'hFFFFFF - i*'h000101, m, 1, 0, "R3");
        // R6 diffusion along a line, R7 line seeding off and on
        for (int ln = 0; ln < 4; ln++)
            for (int i = 0; i < 16; i++)
                px(1, i == 0, 0, 'h3A6C09 + i*'h050307, 2, ln[0], 0, i == 0 ? "R7" : "R6");
        // R8 frame reseeding on, then off
        for (int f = 0; f < 6; f++)
            for (int i = 0; i < 8; i++)
                px(1, i == 0, i == 0, 'h202020 + i*'h111111, 1 + (f % 2), 1, f < 4, "R8");
        // long random run
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom;
            px(r[0] | r[1], r[2:0] == 0, r[9:2] == 0, $urandom & 'hFFFFFF, r[12:11],
               r[13], r[14], "R6 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule